// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a host and an asynchronous NAND flash device. The host hands it one access at a time (a command byte, an address byte, a data write or a data read), and the block plays that access out on the flash pins as a single strobe cycle. Each cycle is a setup phase, a strobe phase with the write or read enable pulled low, a hold phase, and an optional ready-wait phase, after which the level of the device ready pin is captured. Read cycles and write cycles take their phase lengths from separate fields of a 32-bit timing word.

Requests enter on a valid/ready stream. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a cycle is running, while a read result is still waiting to be taken, and while `sw_reset` is high; a request held on the stream during that time is kept by the host and taken later, never lost. Read results leave on a second valid/ready stream: `rsp_valid` stays high with `rsp_data` frozen until the edge where `rsp_ready` is also high.

A two-bit configuration register, written through `cfg_we`, selects the external bus width and can hold the chip enable low. A one-cycle `sw_reset` pulse abandons any cycle, drops a pending read result and clears that register.

Top module: `nand_bus_seq`

## Requirements
- R1: The timing word holds eight 4-bit fields; from bit 0 upward: read setup, read hold, read strobe, read ready-wait, write setup, write hold, write strobe, write ready-wait. A setup, strobe or hold field of v gives v clocks, and 0 gives 16 clocks. After the accepting edge the cycle spends setup clocks, then strobe clocks, then hold clocks, then 2×ready-wait clocks; `busy` is high for exactly that total.
- R2: A data read (`req_op` = 3) pulls `nand_re_n` low for the strobe time, never drives the data bus, and captures `nand_dq_i` on the edge at which `nand_re_n` returns high; that value is presented on `rsp_data` with `rsp_valid`.
- R3: A command request (`req_op` = 0) holds `nand_cle` high and `nand_ale` low for the setup, strobe and hold phases; an address request (`req_op` = 1) does the same with `nand_ale`. The two are never high together.
- R4: A data write (`req_op` = 2) and a data read raise neither `nand_cle` nor `nand_ale`; `nand_we_n` and `nand_re_n` are never low together.
- R5: Command, address and data-write cycles drive `nand_dq_oe` high and the request data on `nand_dq_o` for setup, strobe and hold, and `nand_we_n` is low only while the bus is driven.
- R6: At the edge that ends a cycle (end of hold when ready-wait is 0, else end of ready-wait), `rdy_status` takes the level of `nand_rdy`; it changes at no other time.
- R7: Configuration bit 1 set holds `nand_ce_n` low; clear, `nand_ce_n` is high.
- R8: Configuration bit 0 clear selects an 8-bit bus: the upper byte of `nand_dq_o` is zero and the upper byte of read data is zero. Set, all 16 bits pass.
- R9: A `sw_reset` pulse returns the sequencer to idle on the next edge and clears both configuration bits.
- R10: `req_ready` is low while a cycle is running or a read result is unaccepted; a held request is taken later unchanged; `rsp_data` stays stable while `rsp_valid` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous sequencer reset pulse |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 2 | Bit 0 wide bus, bit 1 force chip enable |
| tac_word | input | 32 | Read and write timing fields |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 16 | Byte or word to put on the bus |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Read result taken |
| rsp_data | output | 16 | Read result |
| busy | output | 1 | Cycle in progress |
| rdy_status | output | 1 | Last sampled device ready level |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_o | output | 16 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 16 | Bus data in |
| nand_rdy | input | 1 | Device ready pin |

## Verification
The hardest situation to reach is proving that read data is taken on the exact edge where the read strobe ends and that the ready pin is sampled only at the last edge of a cycle. The stimulus changes `nand_dq_i` on every strobe clock and holds `nand_rdy` at the opposite of the wanted value until the final busy clock, so capture one edge early or late shows up as a wrong value. Stalls are reached by keeping a second request valid through a running cycle and by withholding `rsp_ready` after a read.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RWAIT  = 3'd4
  } phase_e;

  localparam int FIELDS_PER_DIR = 4;
  localparam int F_SETUP = 0;
  localparam int F_HOLD  = 1;
  localparam int F_WIDTH = 2;
  localparam int F_WAIT  = 3;
endpackage

// File: rtl/nbs_timing_decode.sv
module nbs_timing_decode
  import nbs_pkg::*;
#(
  parameter int FW = 4,
  parameter int CW = FW + 2
) (
  input  logic [2*FIELDS_PER_DIR*FW-1:0] word,
  input  logic                           is_read,
  output logic [CW-1:0]                  setup_len,
  output logic [CW-1:0]                  width_len,
  output logic [CW-1:0]                  hold_len,
  output logic [CW-1:0]                  wait_len
);
  localparam logic [CW-1:0] FULL_SPAN = CW'(1 << FW);

  logic [FW-1:0] sel [FIELDS_PER_DIR];

  for (genvar g = 0; g < FIELDS_PER_DIR; g++) begin : g_field
    logic [FW-1:0] rd_f, wr_f;
    assign rd_f   = word[g*FW +: FW];
    assign wr_f   = word[(FIELDS_PER_DIR+g)*FW +: FW];
    assign sel[g] = is_read ? rd_f : wr_f;
  end

  function automatic logic [CW-1:0] span(input logic [FW-1:0] v);
    return (v == '0) ? FULL_SPAN : CW'(v);
  endfunction

  always_comb begin
    setup_len = span(sel[F_SETUP]);
    width_len = span(sel[F_WIDTH]);
    hold_len  = span(sel[F_HOLD]);
    wait_len  = CW'({sel[F_WAIT], 1'b0});
  end
endmodule

// File: rtl/nbs_cycle_fsm.sv
module nbs_cycle_fsm
  import nbs_pkg::*;
#(
  parameter int CW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_reset,
  input  logic          start,
  input  op_e           start_op,
  input  logic [DW-1:0] start_data,
  input  logic [CW-1:0] setup_len,
  input  logic [CW-1:0] width_len,
  input  logic [CW-1:0] hold_len,
  input  logic [CW-1:0] wait_len,
  input  logic [DW-1:0] dq_in,
  input  logic          rdy_in,
  input  logic          rsp_ready,
  output phase_e        phase,
  output op_e           op_q,
  output logic [DW-1:0] data_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rdy_status
);
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      op_q       <= OP_CMD;
      data_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rdy_status <= 1'b0;
    end else if (sw_reset) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SETUP;
          cnt    <= setup_len - CW'(1);
          op_q   <= start_op;
          data_q <= start_data;
        end
        PH_SETUP: if (last) begin
          phase <= PH_STROBE;
          cnt   <= width_len - CW'(1);
        end else cnt <= cnt - CW'(1);
        PH_STROBE: if (last) begin
          phase <= PH_HOLD;
          cnt   <= hold_len - CW'(1);
          if (op_q == OP_RD) begin
            rsp_data  <= dq_in;
            rsp_valid <= 1'b1;
          end
        end else cnt <= cnt - CW'(1);
        PH_HOLD: if (last) begin
          if (wait_len == '0) begin
            phase      <= PH_IDLE;
            rdy_status <= rdy_in;
          end else begin
            phase <= PH_RWAIT;
            cnt   <= wait_len - CW'(1);
          end
        end else cnt <= cnt - CW'(1);
        PH_RWAIT: if (last) begin
          phase      <= PH_IDLE;
          rdy_status <= rdy_in;
        end else cnt <= cnt - CW'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10: an unaccepted read result keeps its value
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !sw_reset) |=> (rsp_valid && $stable(rsp_data)));

  // R9: software reset abandons the cycle on the next edge
  p_swreset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (phase == PH_IDLE));

  // R1: the strobe phase is entered only from setup
  p_strobe_after_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_STROBE));

  // R6: the ready status moves only when a cycle ends
  p_rdy_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_status != $past(rdy_status)) |-> (phase == PH_IDLE && $past(phase) != PH_IDLE));
endmodule

// File: rtl/nbs_pin_drive.sv
module nbs_pin_drive
  import nbs_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = DW / 2
) (
  input  phase_e        phase,
  input  op_e           op_q,
  input  logic [DW-1:0] data_q,
  input  logic          wide,
  input  logic          ce_force,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic          ce_n,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);
  logic active, is_wr, strobe;

  always_comb begin
    active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strobe = (phase == PH_STROBE);
    is_wr  = (op_q != OP_RD);
    cle    = active && (op_q == OP_CMD);
    ale    = active && (op_q == OP_ADDR);
    we_n   = !(strobe && is_wr);
    re_n   = !(strobe && !is_wr);
    ce_n   = !ce_force;
    dq_oe  = active && is_wr;
    if (!dq_oe)     dq_o = '0;
    else if (wide)  dq_o = data_q;
    else            dq_o = {{(DW-NW){1'b0}}, data_q[NW-1:0]};
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sw_reset,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_wdata,
  input  logic [2*FIELDS_PER_DIR*FW-1:0] tac_word,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [DW-1:0]                req_data,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DW-1:0]                rsp_data,
  output logic                         busy,
  output logic                         rdy_status,
  output logic                         nand_cle,
  output logic                         nand_ale,
  output logic                         nand_we_n,
  output logic                         nand_re_n,
  output logic                         nand_ce_n,
  output logic [DW-1:0]                nand_dq_o,
  output logic                         nand_dq_oe,
  input  logic [DW-1:0]                nand_dq_i,
  input  logic                         nand_rdy
);
  localparam int CW = FW + 2;
  localparam int NW = DW / 2;

  logic          cfg_wide_q, cfg_force_q;
  phase_e        phase;
  op_e           op_q;
  logic [DW-1:0] data_q, dq_eff;
  logic [CW-1:0] setup_len, width_len, hold_len, wait_len;
  logic          start, dir_is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_wide_q  <= 1'b0;
      cfg_force_q <= 1'b0;
    end else if (sw_reset) begin
      cfg_wide_q  <= 1'b0;
      cfg_force_q <= 1'b0;
    end else if (cfg_we) begin
      cfg_wide_q  <= cfg_wdata[0];
      cfg_force_q <= cfg_wdata[1];
    end
  end

  assign busy        = (phase != PH_IDLE);
  assign req_ready   = !busy && !rsp_valid && !sw_reset;
  assign start       = req_valid && req_ready;
  assign dir_is_read = busy ? (op_q == OP_RD) : (op_e'(req_op) == OP_RD);
  assign dq_eff      = cfg_wide_q ? nand_dq_i : {{(DW-NW){1'b0}}, nand_dq_i[NW-1:0]};

  nbs_timing_decode #(.FW(FW), .CW(CW)) u_decode (
    .word      (tac_word),
    .is_read   (dir_is_read),
    .setup_len (setup_len),
    .width_len (width_len),
    .hold_len  (hold_len),
    .wait_len  (wait_len)
  );

  nbs_cycle_fsm #(.CW(CW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .start      (start),
    .start_op   (op_e'(req_op)),
    .start_data (req_data),
    .setup_len  (setup_len),
    .width_len  (width_len),
    .hold_len   (hold_len),
    .wait_len   (wait_len),
    .dq_in      (dq_eff),
    .rdy_in     (nand_rdy),
    .rsp_ready  (rsp_ready),
    .phase      (phase),
    .op_q       (op_q),
    .data_q     (data_q),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rdy_status (rdy_status)
  );

  nbs_pin_drive #(.DW(DW), .NW(NW)) u_pins (
    .phase    (phase),
    .op_q     (op_q),
    .data_q   (data_q),
    .wide     (cfg_wide_q),
    .ce_force (cfg_force_q),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .ce_n     (nand_ce_n),
    .dq_o     (nand_dq_o),
    .dq_oe    (nand_dq_oe)
  );

  // R3: command and address latches never overlap
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R4: write and read strobes never overlap
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R5: write strobe only while the bus is driven
  p_we_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  // R10: no request is taken during a cycle
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
endmodule

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_reset = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_wdata = '0;
  logic [31:0] tac_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [15:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        busy, rdy_status;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
  logic [15:0] nand_dq_o;
  logic [15:0] nand_dq_i = '0;
  logic        nand_rdy = 1'b0;

  int vectors = 0;
  int fails = 0;

  int st_total, st_we_first, st_we_cnt, st_re_first, st_re_cnt;
  int st_cle, st_ale, st_oe, st_rsp_seen;
  logic [15:0] st_dq, st_rsp, rd_base;

  always #10 clk = ~clk;

  nand_bus_seq u_nand_bus_seq (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .tac_word(tac_word), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .rdy_status(rdy_status), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ce_n(nand_ce_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
  );

  function automatic logic [31:0] tac(input int rs, rh, rw, rr, ws, wh, ww, wr);
    return {4'(wr), 4'(ww), 4'(wh), 4'(ws), 4'(rr), 4'(rw), 4'(rh), 4'(rs)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Issue one request and record pin activity on every busy clock
  task automatic run_cycle(input logic [1:0] op, input logic [15:0] data,
                           input logic rdy_tgt, input int exp_total);
    int idx;
    @(negedge clk);
    req_op = op; req_data = data; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    st_we_first = -1; st_we_cnt = 0; st_re_first = -1; st_re_cnt = 0;
    st_cle = 0; st_ale = 0; st_oe = 0; st_rsp_seen = 0; st_dq = '0; st_rsp = '0;
    idx = 0;
    while (busy) begin
      if (!nand_we_n) begin
        if (st_we_cnt == 0) begin st_we_first = idx; st_dq = nand_dq_o; end
        st_we_cnt++;
      end
      if (!nand_re_n) begin
        if (st_re_cnt == 0) st_re_first = idx;
        st_re_cnt++;
        nand_dq_i = rd_base + 16'(st_re_cnt);
      end
      if (nand_cle) st_cle++;
      if (nand_ale) st_ale++;
      if (nand_dq_oe) st_oe++;
      if (rsp_valid && st_rsp_seen == 0) begin st_rsp_seen = 1; st_rsp = rsp_data; end
      nand_rdy = (idx == exp_total - 1) ? rdy_tgt : !rdy_tgt;
      idx++;
      @(negedge clk);
    end
    st_total = idx;
  endtask

  task automatic t_reset_state;
    chk("R10 reset req_ready", req_ready, 1);
    chk("R1 reset busy", busy, 0);
    chk("R4 reset we_n", nand_we_n, 1);
    chk("R4 reset re_n", nand_re_n, 1);
    chk("R7 reset ce_n", nand_ce_n, 1);
    chk("R5 reset dq_oe", nand_dq_oe, 0);
    chk("R2 reset rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_command;
    tac_word = tac(5, 4, 6, 3, 2, 1, 3, 1);
    run_cycle(2'd0, 16'h0070, 1'b1, 8);
    chk("R1 cmd total", st_total, 8);
    chk("R1 cmd we first", st_we_first, 2);
    chk("R1 cmd we width", st_we_cnt, 3);
    chk("R3 cmd cle clocks", st_cle, 6);
    chk("R3 cmd ale clocks", st_ale, 0);
    chk("R5 cmd oe clocks", st_oe, 6);
    chk("R5 cmd dq", st_dq, 16'h0070);
  endtask

  task automatic t_address_zero_fields;
    tac_word = tac(1, 1, 1, 1, 0, 0, 0, 0);
    run_cycle(2'd1, 16'h0033, 1'b0, 48);
    chk("R1 zero field total", st_total, 48);
    chk("R1 zero field we first", st_we_first, 16);
    chk("R1 zero field we width", st_we_cnt, 16);
    chk("R3 addr ale clocks", st_ale, 48);
    chk("R3 addr cle clocks", st_cle, 0);
  endtask

  task automatic t_data_write_widths;
    tac_word = tac(1, 1, 1, 0, 1, 2, 2, 0);
    run_cycle(2'd2, 16'hABCD, 1'b0, 5);
    chk("R8 narrow write dq", st_dq, 16'h00CD);
    chk("R4 data write cle", st_cle, 0);
    chk("R4 data write ale", st_ale, 0);
    set_cfg(2'b01);
    run_cycle(2'd2, 16'hABCD, 1'b0, 5);
    chk("R8 wide write dq", st_dq, 16'hABCD);
  endtask

  task automatic t_read;
    tac_word = tac(3, 2, 4, 2, 1, 1, 1, 0);
    rd_base = 16'h1200;
    run_cycle(2'd3, 16'h0000, 1'b1, 13);
    chk("R2 read total", st_total, 13);
    chk("R2 read re first", st_re_first, 3);
    chk("R2 read re width", st_re_cnt, 4);
    chk("R2 read no drive", st_oe, 0);
    chk("R4 read no we", st_we_cnt, 0);
    chk("R4 read latches", st_cle + st_ale, 0);
    chk("R2 read seen", st_rsp_seen, 1);
    chk("R2 read capture at release", st_rsp, 16'h1204);
    set_cfg(2'b00);
    rd_base = 16'h12F0;
    run_cycle(2'd3, 16'h0000, 1'b1, 13);
    chk("R8 narrow read data", st_rsp, 16'h00F4);
  endtask

  task automatic t_ready_sample;
    tac_word = tac(1, 1, 1, 0, 1, 1, 2, 3);
    run_cycle(2'd2, 16'h0001, 1'b1, 10);
    chk("R6 wait total", st_total, 10);
    chk("R6 sampled high", rdy_status, 1);
    nand_rdy = 1'b1;
    @(negedge clk);
    chk("R6 holds between cycles", rdy_status, 1);
    run_cycle(2'd2, 16'h0002, 1'b0, 10);
    chk("R6 sampled low", rdy_status, 0);
    tac_word = tac(1, 1, 1, 0, 1, 1, 1, 0);
    run_cycle(2'd2, 16'h0003, 1'b1, 3);
    chk("R6 no wait sampled", rdy_status, 1);
  endtask

  task automatic t_ce_force;
    set_cfg(2'b10);
    chk("R7 forced low", nand_ce_n, 0);
    set_cfg(2'b00);
    chk("R7 released high", nand_ce_n, 1);
  endtask

  task automatic t_stall;
    tac_word = tac(1, 1, 1, 0, 1, 1, 1, 0);
    @(negedge clk);
    req_op = 2'd2; req_data = 16'h0011; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_data = 16'h0022;
    chk("R10 not ready while busy", req_ready, 0);
    run_cycle(2'd2, 16'h0022, 1'b0, 3);
    chk("R10 held request kept", st_dq, 16'h0022);
    rsp_ready = 1'b0;
    rd_base = 16'h0050;
    run_cycle(2'd3, 16'h0000, 1'b0, 3);
    chk("R10 rsp pending", rsp_valid, 1);
    chk("R10 not ready with rsp", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R10 rsp data stable", rsp_data, 16'h0051);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 rsp taken", rsp_valid, 0);
  endtask

  task automatic t_sw_reset;
    set_cfg(2'b11);
    tac_word = tac(1, 1, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_op = 2'd2; req_data = 16'hBEEF; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 busy before reset", busy, 1);
    sw_reset = 1'b1;
    @(negedge clk);
    sw_reset = 1'b0;
    chk("R9 idle after reset", busy, 0);
    chk("R9 force cleared", nand_ce_n, 1);
    chk("R9 bus released", nand_dq_oe, 0);
    tac_word = tac(1, 1, 1, 0, 1, 1, 1, 0);
    run_cycle(2'd2, 16'hABCD, 1'b0, 3);
    chk("R9 width cleared", st_dq, 16'h00CD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rd_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_command();
    t_address_zero_fields();
    t_data_write_widths();
    t_read();
    t_ready_sample();
    t_ce_force();
    t_stall();
    t_sw_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule